// File: doc/BRIEF.md
# Pipeline Hazard Stall and Flush Controller

This block is the hazard control unit of a five-stage in-order integer pipeline. The stages are fetch, decode with register read, execute, memory access and write-back. It watches three points of the pipeline:

- the source register fields of the instruction in decode;
- the destination register and load flag of the instruction held between decode and execute;
- the branch outcome of the instruction in the memory stage.

From these it drives the write enables, bubble and flush controls of the pipeline registers.

Two situations need action. The first is a load directly followed by an instruction that reads the loaded register. Forwarding cannot cover this case, so the consumer is held in decode for one cycle. The PC and the fetch/decode register keep their contents, and a bubble enters the execute stage.

The second is a branch. Fetch is predicted not taken, and branches resolve in the memory stage. A taken branch therefore redirects the PC to its target and squashes the three younger instructions in the fetch/decode, decode/execute and execute/memory registers. No wrong-path instruction ever writes architectural state.

The controls are combinational. They act within the cycle in which the hazard is seen.

Top module: `hzd_ctrl`

## Requirements
- R1: With no load-use match and no taken branch, `pc_we` and `ifid_we` are 1, and `idex_bubble`, `pc_redirect` and all three flush outputs are 0.
- R2: When `id_valid`, `ex_valid` and `ex_mem_read` are all 1, and some source whose used bit is set has an index equal to `ex_dst`, the same cycle shows `pc_we`=0, `ifid_we`=0 and `idex_bubble`=1. Each such load-consumer pair costs exactly one bubble. Source k occupies bits [k*REG_W +: REG_W] of `id_src_idx` and bit k of `id_src_used`.
- R3: A source whose used bit is 0 never causes a stall, whatever its index field holds.
- R4: With ZERO_REG=1, a load whose destination index is 0 never causes a stall.
- R5: When `mem_br_resolved` and `mem_br_taken` are both 1, the same cycle shows `pc_redirect`=1, `pc_we`=1 and all three flush outputs at 1. A taken branch costs exactly three lost cycles.
- R6: When a taken branch and a load-use match coincide, the flush wins: `idex_bubble`=0 and `pc_we`=1.
- R7: A branch that resolves not taken gives `pc_redirect`=0 and no flush.
- R8: In a running pipeline, no instruction on the wrong path of a taken branch reaches write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables the checks |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_src_idx | input | NUM_SRC*REG_W | Packed source register indices of the decode instruction |
| id_src_used | input | NUM_SRC | Per-source flag: the instruction really reads that source |
| ex_valid | input | 1 | Decode/execute register holds a valid instruction |
| ex_mem_read | input | 1 | That instruction is a load |
| ex_dst | input | REG_W | Destination register index of that instruction |
| mem_br_resolved | input | 1 | A valid branch is resolving in the memory stage |
| mem_br_taken | input | 1 | That branch is taken |
| pc_we | output | 1 | PC write enable |
| pc_redirect | output | 1 | PC loads the branch target instead of the sequential address |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control bits entering decode/execute |
| ifid_flush | output | 1 | Invalidate fetch/decode register |
| idex_flush | output | 1 | Invalidate decode/execute register |
| exmem_flush | output | 1 | Invalidate execute/memory register |

## Verification
Several relations are checked on every cycle:

- A stall always freezes the PC and the fetch/decode register.
- A stall only occurs with a load in execute.
- A redirect always raises all three flushes and never coexists with a bubble.
- A load to register zero never stalls.

The bench sweeps every input combination of a two-bit-index configuration against arithmetic expectations. Only a running pipeline model can show the end-to-end costs: one bubble per load-consumer pair, three lost cycles per taken branch, and no wrong-path retirement. These appear in the total cycle count of a program that mixes all of these cases.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef struct packed {
    logic pc_we;
    logic pc_redirect;
    logic ifid_we;
    logic idex_bubble;
    logic ifid_flush;
    logic idex_flush;
    logic exmem_flush;
  } hzd_ctl_t;

endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int REG_W    = 5,
  parameter int NUM_SRC  = 2,
  parameter bit ZERO_REG = 1'b1
) (
  input  logic                     id_valid,
  input  logic [NUM_SRC*REG_W-1:0] src_idx,
  input  logic [NUM_SRC-1:0]       src_used,
  input  logic                     ex_valid,
  input  logic                     ex_mem_read,
  input  logic [REG_W-1:0]         ex_dst,
  output logic                     load_use
);

  logic [NUM_SRC-1:0] hit;
  logic               dst_live;

  // One comparator per source; unused sources are masked out (R3).
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_cmp
    assign hit[k] = src_used[k] && (src_idx[k*REG_W +: REG_W] == ex_dst);
  end

  // A hardwired zero register never carries a real load result (R4).
  if (ZERO_REG) begin : g_zero
    assign dst_live = (ex_dst != '0);
  end else begin : g_nozero
    assign dst_live = 1'b1;
  end

  assign load_use = id_valid && ex_valid && ex_mem_read && dst_live && (|hit);

endmodule

// File: rtl/hzd_arbiter.sv
module hzd_arbiter
  import hzd_pkg::*;
(
  input  logic     load_use,
  input  logic     br_resolved,
  input  logic     br_taken,
  output hzd_ctl_t ctl
);

  logic redirect;
  logic stall;

  assign redirect = br_resolved && br_taken;
  // Flush outranks stall: the stalled consumer is on the wrong path anyway (R6).
  assign stall    = load_use && !redirect;

  always_comb begin
    ctl             = '0;
    ctl.pc_we       = !stall;
    ctl.ifid_we     = !stall;
    ctl.idex_bubble = stall;
    ctl.pc_redirect = redirect;
    ctl.ifid_flush  = redirect;
    ctl.idex_flush  = redirect;
    ctl.exmem_flush = redirect;
  end

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_W    = 5,
  parameter int NUM_SRC  = 2,
  parameter bit ZERO_REG = 1'b1,
  localparam int SRC_W   = NUM_SRC * REG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               id_valid,
  input  logic [SRC_W-1:0]   id_src_idx,
  input  logic [NUM_SRC-1:0] id_src_used,
  input  logic               ex_valid,
  input  logic               ex_mem_read,
  input  logic [REG_W-1:0]   ex_dst,
  input  logic               mem_br_resolved,
  input  logic               mem_br_taken,
  output logic               pc_we,
  output logic               pc_redirect,
  output logic               ifid_we,
  output logic               idex_bubble,
  output logic               ifid_flush,
  output logic               idex_flush,
  output logic               exmem_flush
);

  logic     load_use;
  hzd_ctl_t ctl;

  hzd_src_match #(
    .REG_W   (REG_W),
    .NUM_SRC (NUM_SRC),
    .ZERO_REG(ZERO_REG)
  ) u_match (
    .id_valid   (id_valid),
    .src_idx    (id_src_idx),
    .src_used   (id_src_used),
    .ex_valid   (ex_valid),
    .ex_mem_read(ex_mem_read),
    .ex_dst     (ex_dst),
    .load_use   (load_use)
  );

  hzd_arbiter u_arb (
    .load_use   (load_use),
    .br_resolved(mem_br_resolved),
    .br_taken   (mem_br_taken),
    .ctl        (ctl)
  );

  assign pc_we       = ctl.pc_we;
  assign pc_redirect = ctl.pc_redirect;
  assign ifid_we     = ctl.ifid_we;
  assign idex_bubble = ctl.idex_bubble;
  assign ifid_flush  = ctl.ifid_flush;
  assign idex_flush  = ctl.idex_flush;
  assign exmem_flush = ctl.exmem_flush;

  assert_stall_freezes_R2: assert property (@(posedge clk) disable iff (rst)
    idex_bubble |-> (!pc_we && !ifid_we));

  assert_stall_needs_load_R2: assert property (@(posedge clk) disable iff (rst)
    idex_bubble |-> (ex_valid && ex_mem_read && id_valid));

  assert_zero_dst_no_stall_R4: assert property (@(posedge clk) disable iff (rst)
    (ZERO_REG && ex_dst == '0) |-> !idex_bubble);

  assert_taken_flushes_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_br_resolved && mem_br_taken) |->
      (pc_redirect && pc_we && ifid_flush && idex_flush && exmem_flush));

  assert_flush_beats_stall_R6: assert property (@(posedge clk) disable iff (rst)
    pc_redirect |-> !idex_bubble);

  assert_not_taken_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !mem_br_taken |-> !(pc_redirect || ifid_flush || idex_flush || exmem_flush));

endmodule

// File: tb/test_hzd_ctrl.sv
module test_hzd_ctrl;

  localparam int RW = 2;
  localparam int NS = 2;
  localparam int NP = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  // DUT inputs: sweep drivers or pipeline-model drivers
  logic          sweep_on = 1'b1;
  logic          sw_iv, sw_ev, sw_mr, sw_res, sw_tk;
  logic [2*RW-1:0] sw_src;
  logic [1:0]    sw_used;
  logic [RW-1:0] sw_dst;

  logic          d_iv, d_ev, d_mr, d_res, d_tk;
  logic [2*RW-1:0] d_src;
  logic [1:0]    d_used;
  logic [RW-1:0] d_dst;
  logic pc_we, pc_redirect, ifid_we, idex_bubble, ifid_flush, idex_flush, exmem_flush;

  // Program model
  logic          p_ld  [NP];
  logic [RW-1:0] p_dst [NP];
  logic [RW-1:0] p_s1  [NP];
  logic [RW-1:0] p_s2  [NP];
  logic          p_u1  [NP];
  logic          p_u2  [NP];
  logic          p_br  [NP];
  logic          p_tk  [NP];
  logic          p_pz  [NP];
  logic [4:0]    p_tgt [NP];

  logic       pipe_rst = 1'b1;
  logic [4:0] pc;
  logic       ifid_v, idex_v, exmem_v, memwb_v;
  logic [4:0] ifid_i, idex_i, exmem_i, memwb_i;
  int cyc, retired, wrong, last_cyc, bubbles, flushes;

  assign d_iv   = sweep_on ? sw_iv   : ifid_v;
  assign d_src  = sweep_on ? sw_src  : {p_s2[ifid_i], p_s1[ifid_i]};
  assign d_used = sweep_on ? sw_used : {p_u2[ifid_i], p_u1[ifid_i]};
  assign d_ev   = sweep_on ? sw_ev   : idex_v;
  assign d_mr   = sweep_on ? sw_mr   : p_ld[idex_i];
  assign d_dst  = sweep_on ? sw_dst  : p_dst[idex_i];
  assign d_res  = sweep_on ? sw_res  : (exmem_v && p_br[exmem_i]);
  assign d_tk   = sweep_on ? sw_tk   : p_tk[exmem_i];

  hzd_ctrl #(.REG_W(RW), .NUM_SRC(NS), .ZERO_REG(1'b1)) i_hzd_ctrl (
    .clk(clk), .rst(rst),
    .id_valid(d_iv), .id_src_idx(d_src), .id_src_used(d_used),
    .ex_valid(d_ev), .ex_mem_read(d_mr), .ex_dst(d_dst),
    .mem_br_resolved(d_res), .mem_br_taken(d_tk),
    .pc_we(pc_we), .pc_redirect(pc_redirect), .ifid_we(ifid_we),
    .idex_bubble(idex_bubble), .ifid_flush(ifid_flush),
    .idex_flush(idex_flush), .exmem_flush(exmem_flush)
  );

  // Bench-side pipeline driven by the controller
  always @(posedge clk) begin
    if (pipe_rst) begin
      pc <= '0; ifid_v <= 1'b0; idex_v <= 1'b0; exmem_v <= 1'b0; memwb_v <= 1'b0;
      ifid_i <= '0; idex_i <= '0; exmem_i <= '0; memwb_i <= '0;
      cyc <= 0; retired <= 0; wrong <= 0; last_cyc <= 0; bubbles <= 0; flushes <= 0;
    end else begin
      cyc <= cyc + 1;
      if (memwb_v) begin
        retired  <= retired + 1;
        last_cyc <= cyc;
        if (p_pz[memwb_i]) wrong <= wrong + 1;
      end
      if (idex_bubble) bubbles <= bubbles + 1;
      if (pc_redirect) flushes <= flushes + 1;
      if (pc_we) pc <= pc_redirect ? p_tgt[exmem_i] : ((pc < 5'(NP)) ? pc + 5'd1 : pc);
      if (ifid_flush) ifid_v <= 1'b0;
      else if (ifid_we) begin ifid_v <= (pc < 5'(NP)); ifid_i <= (pc < 5'(NP)) ? pc : '0; end
      if (idex_flush || idex_bubble) idex_v <= 1'b0;
      else begin idex_v <= ifid_v; idex_i <= ifid_i; end
      if (exmem_flush) exmem_v <= 1'b0;
      else begin exmem_v <= idex_v; exmem_i <= idex_i; end
      memwb_v <= exmem_v; memwb_i <= exmem_i;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic ins(input int i, input bit ld, input int dst, input int s1, input bit u1,
                     input int s2, input bit u2, input bit br, input bit tk,
                     input int tgt, input bit pz);
    p_ld[i] = ld; p_dst[i] = RW'(dst); p_s1[i] = RW'(s1); p_u1[i] = u1;
    p_s2[i] = RW'(s2); p_u2[i] = u2; p_br[i] = br; p_tk[i] = tk;
    p_tgt[i] = 5'(tgt); p_pz[i] = pz;
  endtask

  initial begin
    for (int i = 0; i < NP; i++) ins(i, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    ins(0,  1, 1, 0, 0, 0, 0, 0, 0, 0, 0);   // load r1
    ins(1,  0, 2, 1, 1, 3, 1, 0, 0, 0, 0);   // reads r1 on source 0: one bubble
    ins(2,  0, 3, 2, 1, 2, 1, 0, 0, 0, 0);   // reads ALU result: no bubble
    ins(3,  1, 2, 0, 0, 0, 0, 0, 0, 0, 0);   // load r2
    ins(4,  0, 3, 3, 1, 2, 1, 0, 0, 0, 0);   // reads r2 on source 1: one bubble
    ins(5,  1, 0, 0, 0, 0, 0, 0, 0, 0, 0);   // load to r0
    ins(6,  0, 1, 0, 1, 0, 1, 0, 0, 0, 0);   // reads r0: no bubble
    ins(7,  1, 3, 0, 0, 0, 0, 0, 0, 0, 0);   // load r3
    ins(8,  0, 1, 3, 0, 3, 0, 0, 0, 0, 0);   // r3 in fields, unused: no bubble
    ins(9,  0, 0, 0, 0, 0, 0, 1, 1, 13, 0);  // taken branch to 13
    ins(10, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);   // wrong path
    ins(11, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    ins(12, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1);
    ins(13, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0);   // not-taken branch
    ins(14, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0);   // load r1
    ins(15, 0, 2, 2, 1, 2, 1, 0, 0, 0, 0);
    ins(16, 0, 3, 1, 1, 1, 1, 0, 0, 0, 0);   // reads r1 two behind: no bubble

    {sw_iv, sw_ev, sw_mr, sw_res, sw_tk, sw_src, sw_used, sw_dst} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // Idle/reset state (R1)
    #1;
    chk("R1", "pc_we idle", pc_we, 1);
    chk("R1", "flush idle", ifid_flush | idex_flush | exmem_flush, 0);
    chk("R1", "bubble idle", idex_bubble, 0);

    // Exhaustive sweep of all 2^13 input combinations
    for (int v = 0; v < 8192; v++) begin
      @(negedge clk);
      {sw_iv, sw_ev, sw_mr, sw_res, sw_tk, sw_src, sw_used, sw_dst} = 13'(v);
      #1;
      begin
        bit m1, m2, raw, lu, rd, st;
        string tag;
        m1  = (sw_src[RW-1:0] == sw_dst);
        m2  = (sw_src[2*RW-1:RW] == sw_dst);
        raw = sw_iv && sw_ev && sw_mr && ((m1 && sw_used[0]) || (m2 && sw_used[1]));
        lu  = raw && (sw_dst != 0);
        rd  = sw_res && sw_tk;
        st  = lu && !rd;
        if (rd && lu)                                tag = "R6";
        else if (rd)                                 tag = "R5";
        else if (lu)                                 tag = "R2";
        else if (raw)                                tag = "R4";
        else if (sw_iv && sw_ev && sw_mr && (m1 || m2)) tag = "R3";
        else if (sw_res)                             tag = "R7";
        else                                         tag = "R1";
        chk(tag, $sformatf("ctl vec=%0d", v),
            {pc_we, pc_redirect, ifid_we, idex_bubble, ifid_flush, idex_flush, exmem_flush},
            {!st, rd, !st, st, rd, rd, rd});
      end
    end

    // Pipeline run: 14 executed, 2 load-use bubbles, 1 taken branch
    @(negedge clk) sweep_on = 1'b0;
    @(negedge clk) pipe_rst = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk("R2", "bubble count", bubbles, 2);
    chk("R5", "redirect count", flushes, 1);
    chk("R8", "wrong-path retired", wrong, 0);
    chk("R8", "retired count", retired, 14);
    chk("R5", "last retire cycle", last_cyc, 13 + 4 + 2 + 3);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule